// File: doc/BRIEF.md
# ADC Serial Read Controller

This block is the host side of a link to a 16-bit converter with serial output. It starts a new conversion and, while that conversion runs, reads out the result of the previous one. The bit clock it drives to the converter never stops. It is a divided version of the system clock and toggles every `DIV` system cycles, whether or not a read is in progress.

A read begins on `start`. The block lowers chip-select and the read/convert strobe together. It holds the strobe low until two things have happened: at least one bit-clock transition has completed while both lines are low, and the converter has lowered its active-low busy line. It then raises the strobe and waits a programmable number of system cycles. The next rising bit-clock edge after that wait is the sync request. The sync flag is sampled on falling bit-clock edges. The 16 falling edges after the one where sync is seen carry the word, most significant bit first.

When the last bit arrives, the block raises chip-select and presents the word with a one-cycle valid pulse. If sync does not arrive in time, the block abandons the read and sets a sticky error flag. The read starts as soon as busy falls, so the whole word arrives early in the busy period.

Top module: `adc_rd_ctrl`

## Requirements
- R1: A `start` pulse seen while idle drives `cs_n` and `rc_n` low together at the next clock edge. `rc_n` is never low while `cs_n` is high.
- R2: `rc_n` returns high only after both of the following hold: at least one `sclk` transition has completed with `cs_n` and `rc_n` low, and `busy_n` is low. While `busy_n` stays high, `rc_n` stays low.
- R3: The sync request is the first rising `sclk` edge that comes at least `SETUP_CYC`+1 system cycles after `rc_n` rises.
- R4: `sync_in` is sampled on falling `sclk` edges. Sync is accepted on any of the first `SYNC_TMO` falling edges after the request edge.
- R5: The `DATA_W` falling edges that follow the accepting edge each sample one bit of `sdata_in`. The first of them gives bit 15, the MSB, and the last gives bit 0. The assembled word appears on `data_out`.
- R6: `data_valid` is high for exactly one system cycle, starting one cycle after the cycle of the last bit's falling edge. `cs_n` returns high at the same edge. `data_out` holds its value until the next completed read.
- R7: If no sync is seen on `SYNC_TMO` falling edges, the following happens: `timeout_err` is set, `cs_n` and `rc_n` go high, and no valid pulse is produced. The flag stays set until the next accepted `start` clears it.
- R8: `start` has no effect while a read is in progress. No second read is started and no extra valid pulse is produced.
- R9: `sclk` toggles every `DIV` system cycles without a break, including while the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one conversion-and-read sequence |
| busy_n | input | 1 | Converter busy, low while converting |
| sync_in | input | 1 | Serial sync flag from the converter |
| sdata_in | input | 1 | Serial data from the converter |
| sclk | output | 1 | Continuous bit clock to the converter |
| cs_n | output | 1 | Active-low chip-select |
| rc_n | output | 1 | Read/convert strobe, low starts a conversion |
| data_out | output | DATA_W | Last word captured |
| data_valid | output | 1 | One-cycle pulse when `data_out` is updated |
| timeout_err | output | 1 | Sticky flag: sync not seen in time |

## Verification
A sequencer whose edge counting is off by one shows this at the ports in two ways. The captured word comes out shifted by a bit, or the read times out when sync is sent on the last edge of the window. Both are visible within about 20 bit-clock periods of the request. A strobe that rises early is seen at once on `rc_n` while `busy_n` is still high. A shift register or framing counter in the wrong state gives a wrong `data_out`, or a valid pulse that is missing, doubled or late, all on the read in which the fault occurs. A stuck error flag or a start that should have been ignored shows on the next sequence.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        RD_IDLE = 3'd0,
        RD_ARM  = 3'd1,
        RD_HOLD = 3'd2,
        RD_REQ  = 3'd3,
        RD_SYNC = 3'd4,
        RD_BITS = 3'd5
    } rd_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic sclk,
    output logic rise_p,
    output logic fall_p
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } gen_t;

    gen_t g_d, g_q;
    logic wrap;

    always_comb begin
        g_d  = g_q;
        wrap = (g_q.cnt == CW'(DIV - 1));
        if (wrap) begin
            g_d.cnt = '0;
            g_d.lvl = ~g_q.lvl;
        end else begin
            g_d.cnt = g_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign sclk   = g_q.lvl;
    assign rise_p = wrap && !g_q.lvl;
    assign fall_p = wrap &&  g_q.lvl;

    assert_rise_goes_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_p |=> sclk);
    assert_fall_goes_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fall_p |=> !sclk);

endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
    import adc_rd_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int SETUP_CYC = 2,
    parameter int SYNC_TMO  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic busy_n,
    input  logic sync_in,
    input  logic rise_p,
    input  logic fall_p,
    output logic cs_n,
    output logic rc_n,
    output logic shift_en,
    output logic word_done,
    output logic timeout_err
);
    localparam int CMAX = max3(SETUP_CYC, SYNC_TMO, DATA_W);
    localparam int CW   = $clog2(CMAX + 1);

    typedef struct packed {
        rd_state_e     st;
        logic [CW-1:0] cnt;
        logic          armed;
        logic          cs_n;
        logic          rc_n;
        logic          tmo;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        shift_en  = 1'b0;
        word_done = 1'b0;
        unique case (s_q.st)
            RD_IDLE: begin
                s_d.cs_n = 1'b1;
                s_d.rc_n = 1'b1;
                if (start) begin
                    s_d.st    = RD_ARM;
                    s_d.cs_n  = 1'b0;
                    s_d.rc_n  = 1'b0;
                    s_d.armed = 1'b0;
                    s_d.tmo   = 1'b0;
                end
            end
            RD_ARM: begin
                if (rise_p || fall_p) s_d.armed = 1'b1;
                if (s_q.armed && !busy_n) begin
                    s_d.st   = RD_HOLD;
                    s_d.rc_n = 1'b1;
                    s_d.cnt  = '0;
                end
            end
            RD_HOLD: begin
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == CW'(SETUP_CYC - 1)) s_d.st = RD_REQ;
            end
            RD_REQ: begin
                if (rise_p) begin
                    s_d.st  = RD_SYNC;
                    s_d.cnt = '0;
                end
            end
            RD_SYNC: begin
                if (fall_p) begin
                    if (sync_in) begin
                        s_d.st  = RD_BITS;
                        s_d.cnt = '0;
                    end else if (s_q.cnt == CW'(SYNC_TMO - 1)) begin
                        s_d.st   = RD_IDLE;
                        s_d.tmo  = 1'b1;
                        s_d.cs_n = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            RD_BITS: begin
                if (fall_p) begin
                    shift_en = 1'b1;
                    if (s_q.cnt == CW'(DATA_W - 1)) begin
                        word_done = 1'b1;
                        s_d.st    = RD_IDLE;
                        s_d.cs_n  = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            default: s_d.st = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= RD_IDLE;
            s_q.cs_n <= 1'b1;
            s_q.rc_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cs_n        = s_q.cs_n;
    assign rc_n        = s_q.rc_n;
    assign timeout_err = s_q.tmo;

    assert_rc_inside_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rc_n |-> !cs_n);
    assert_rc_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $rose(rc_n)) |-> $past(!busy_n));
    assert_tmo_ends_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (cs_n && rc_n));
    assert_done_only_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> fall_p);

endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              word_done,
    input  logic              sdata_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_valid
);
    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] dout;
        logic              vld;
    } shf_t;

    shf_t f_d, f_q;
    logic [DATA_W-1:0] next_sh;

    always_comb begin
        f_d     = f_q;
        next_sh = {f_q.sh[DATA_W-2:0], sdata_in};
        f_d.vld = 1'b0;
        if (shift_en) f_d.sh = next_sh;
        if (word_done) begin
            f_d.dout = next_sh;
            f_d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign data_out   = f_q.dout;
    assign data_valid = f_q.vld;

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);
    assert_dout_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid |-> $stable(data_out));

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
    parameter int DATA_W    = 16,
    parameter int DIV       = 2,
    parameter int SETUP_CYC = 2,
    parameter int SYNC_TMO  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              busy_n,
    input  logic              sync_in,
    input  logic              sdata_in,
    output logic              sclk,
    output logic              cs_n,
    output logic              rc_n,
    output logic [DATA_W-1:0] data_out,
    output logic              data_valid,
    output logic              timeout_err
);
    logic rise_p, fall_p, shift_en, word_done;

    adc_sclk_gen #(.DIV(DIV)) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk   (sclk),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    adc_rd_seq #(
        .DATA_W    (DATA_W),
        .SETUP_CYC (SETUP_CYC),
        .SYNC_TMO  (SYNC_TMO)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .busy_n      (busy_n),
        .sync_in     (sync_in),
        .rise_p      (rise_p),
        .fall_p      (fall_p),
        .cs_n        (cs_n),
        .rc_n        (rc_n),
        .shift_en    (shift_en),
        .word_done   (word_done),
        .timeout_err (timeout_err)
    );

    adc_rd_shift #(.DATA_W(DATA_W)) u_shf (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .word_done  (word_done),
        .sdata_in   (sdata_in),
        .data_out   (data_out),
        .data_valid (data_valid)
    );

    assert_valid_closes_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> cs_n);

endmodule

// File: tb/adc_rd_ctrl_bench.sv
`timescale 1ns/1ps
module adc_rd_ctrl_bench;
    localparam int CLK_P = 10;
    localparam int DW    = 16;
    localparam int DIV   = 2;
    localparam int SETUP = 2;
    localparam int TMO   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy_n = 1'b1;
    logic sync_in = 1'b0;
    logic sdata_in = 1'b0;
    logic sclk, cs_n, rc_n, data_valid, timeout_err;
    logic [DW-1:0] data_out;

    int n_chk = 0;
    int n_fail = 0;
    int vcnt = 0;
    bit done_flag = 0;

    // converter model controls
    logic [DW-1:0] word = '0;
    int  sync_dly = 0;
    bit  send_sync = 1;
    int  busy_lat = 3;
    int  bcnt = 0;
    time rc_t = 0;
    bit  req_seen = 0;
    int  pcnt = 0;

    always #(CLK_P/2) clk = ~clk;

    adc_rd_ctrl #(.DATA_W(DW), .DIV(DIV), .SETUP_CYC(SETUP), .SYNC_TMO(TMO)) u_adc_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .busy_n(busy_n),
        .sync_in(sync_in), .sdata_in(sdata_in), .sclk(sclk), .cs_n(cs_n),
        .rc_n(rc_n), .data_out(data_out), .data_valid(data_valid),
        .timeout_err(timeout_err)
    );

    always @(posedge clk) if (rst_n && data_valid) vcnt <= vcnt + 1;

    // busy model: falls busy_lat cycles after chip-select goes low
    always @(posedge clk) begin
        if (!rst_n || cs_n) begin
            busy_n <= 1'b1;
            bcnt   <= 0;
        end else if (busy_n) begin
            if (bcnt >= busy_lat) busy_n <= 1'b0;
            else                  bcnt   <= bcnt + 1;
        end
    end

    always @(negedge rc_n) rc_t = 64'd1 << 40;
    always @(posedge rc_n) rc_t = $time;

    // serial model: sync and bits launched on rising sclk edges
    always @(posedge sclk) begin
        if (cs_n) begin
            req_seen = 0;
            pcnt = 0;
        end else if (rc_n && !busy_n) begin
            if (!req_seen) begin
                if ($time >= rc_t + (SETUP + 1) * CLK_P) begin
                    req_seen = 1;
                    pcnt = 1;
                end
            end else begin
                pcnt++;
            end
        end
        sync_in  <= req_seen && send_sync && (pcnt == 1 + sync_dly);
        sdata_in <= (req_seen && pcnt >= 2 + sync_dly && pcnt <= DW + 1 + sync_dly)
                    ? word[DW - 1 - (pcnt - 2 - sync_dly)] : 1'b0;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_end(output bit got_v, output bit got_t);
        got_v = 0;
        got_t = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (data_valid) begin got_v = 1; break; end
            if (timeout_err) begin got_t = 1; break; end
        end
    endtask

    task automatic t_reset();
        check(cs_n == 1'b1, "R1 reset cs_n", cs_n, 1);
        check(rc_n == 1'b1, "R1 reset rc_n", rc_n, 1);
        check(data_valid == 1'b0, "R6 reset valid", data_valid, 0);
        check(timeout_err == 1'b0, "R7 reset tmo", timeout_err, 0);
    endtask

    task automatic t_sclk_run();
        int tog = 0;
        logic prev;
        @(negedge clk) prev = sclk;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sclk != prev) tog++;
            prev = sclk;
        end
        check(tog == 40 / DIV, "R9 sclk toggles idle", tog, 40 / DIV);
    endtask

    task automatic t_read(input logic [DW-1:0] w, input int dly, input int blat, input string tag);
        bit gv, gt;
        int v0;
        word = w; sync_dly = dly; send_sync = 1; busy_lat = blat;
        v0 = vcnt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(!cs_n && !rc_n, {"R1 start lowers cs/rc ", tag}, {cs_n, rc_n}, 0);
        check(timeout_err == 1'b0, {"R7 start clears tmo ", tag}, timeout_err, 0);
        wait_end(gv, gt);
        check(gv && !gt, {"R4 sync accepted ", tag}, {gv, gt}, 2);
        check(data_out == w, {"R5 word ", tag}, data_out, w);
        check(cs_n == 1'b1, {"R6 cs_n high at valid ", tag}, cs_n, 1);
        @(negedge clk);
        check(data_valid == 1'b0, {"R6 single pulse ", tag}, data_valid, 0);
        check(vcnt == v0 + 1, {"R6 valid count ", tag}, vcnt, v0 + 1);
    endtask

    task automatic t_busy_hold();
        bit gv, gt;
        word = 16'h1234; sync_dly = 0; send_sync = 1; busy_lat = 20;
        pulse_start();
        repeat (15) @(negedge clk);
        check(rc_n == 1'b0 && busy_n == 1'b1, "R2 rc_n held while busy high", rc_n, 0);
        wait_end(gv, gt);
        check(gv && data_out == 16'h1234, "R2 read after late busy", data_out, 16'h1234);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_timeout();
        bit gv, gt;
        int v0;
        word = 16'hFFFF; send_sync = 0; busy_lat = 3;
        v0 = vcnt;
        pulse_start();
        wait_end(gv, gt);
        check(gt && !gv, "R7 timeout raised", {gv, gt}, 1);
        check(cs_n && rc_n, "R7 lines released", {cs_n, rc_n}, 3);
        repeat (30) @(negedge clk);
        check(timeout_err == 1'b1, "R7 flag sticky", timeout_err, 1);
        check(vcnt == v0, "R7 no valid on timeout", vcnt, v0);
        send_sync = 1;
    endtask

    task automatic t_start_ignored();
        bit gv, gt;
        int v0;
        word = 16'h5A0F; sync_dly = 0; send_sync = 1; busy_lat = 3;
        v0 = vcnt;
        pulse_start();
        repeat (30) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_end(gv, gt);
        check(data_out == 16'h5A0F, "R8 word unaffected", data_out, 16'h5A0F);
        repeat (40) @(negedge clk);
        check(cs_n == 1'b1, "R8 no second read", cs_n, 1);
        check(vcnt == v0 + 1, "R8 one valid only", vcnt, v0 + 1);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sclk_run();
        t_read(16'hA5C3, 0, 3, "basic");
        repeat (5) @(negedge clk);
        t_read(16'h8000, 0, 0, "msb only");
        repeat (5) @(negedge clk);
        t_read(16'h0001, 1, 3, "lsb only");
        repeat (5) @(negedge clk);
        t_read(16'h3C96, TMO - 1, 3, "R3 last sync slot");
        repeat (5) @(negedge clk);
        t_busy_hold();
        t_timeout();
        t_read(16'hFFFF, 2, 5, "after timeout");
        repeat (5) @(negedge clk);
        t_start_ignored();
        t_sclk_run();
        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule